// File: doc/BRIEF.md
# GPIO Bank with Edge Detection

This block is one bank of general-purpose pins behind a simple single-cycle register bus. Software controls an output latch with write-only set and clear registers. A direction register, which can be inverted per pin, decides which pins drive. The bank brings the pad inputs into the clock domain through a two-flop synchronizer and returns the synchronized level on a readback register, whatever the pin's direction.

Each pin has its own rising-edge and falling-edge enable bit. An enabled transition of the synchronized pin latches a sticky status bit, which software clears by writing one to it. A report mask selects which latched bits may raise the single interrupt line. The interrupt is the OR of the masked status bits, taken through a register. The set and clear registers act only on bits written as one. Software can therefore restore a saved output level with two writes: the saved word to set, then its complement to clear.

Writes take effect at the clock edge where `bus_we` is high. Read data is combinational from `bus_addr` and is valid in the same cycle.

Top module: `gpio_edge_bank`

## Requirements
- R1: Register byte offsets are level 0x00 (read-only), direction 0x0C, set 0x18 (write-only), clear 0x24 (write-only), rising-enable 0x30, falling-enable 0x3C, edge-status 0x48, report-mask 0x9C. Direction, rising-enable, falling-enable and report-mask read back the last value written. The set and clear offsets, and any unmapped offset, read as 0.
- R2: A write to the set offset makes every output-latch bit written as 1 equal 1 from the next cycle. Bits written as 0 keep their value.
- R3: A write to the clear offset makes every output-latch bit written as 1 equal 0 from the next cycle. Bits written as 0 keep their value.
- R4: The level register returns the pad input as it was two clock edges earlier (two-flop synchronizer), regardless of the pin's direction.
- R5: A status bit becomes 1 on a 0-to-1 change of the synchronized pin when its rising-enable bit is 1. With the enable at 0, a rising change sets nothing. A pad change is visible in status after the third following clock edge.
- R6: A status bit becomes 1 on a 1-to-0 change of the synchronized pin when its falling-enable bit is 1. With the enable at 0, a falling change sets nothing.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: If an enabled edge of a pin arrives in the same cycle as a write of 1 to that pin's status bit, the bit remains 1.
- R9: `gpio_oe[i]` equals direction bit i XOR bit i of parameter `DIR_INV`. For non-inverted pins 1 means output; for inverted pins 0 means output.
- R10: `irq` is a register holding the OR of (status AND report-mask). It follows a change of either one clock edge later, and it stays 0 while no latched bit is unmasked.
- R11: After reset the direction, both enable registers, the report mask, the output latch and the status are 0, `irq` is 0, and `gpio_oe` equals `DIR_INV`.
- R12: Writing a word S to set and then ~S to clear leaves the output latch equal to S, whatever its prior value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Combinational read data for `bus_addr` |
| pad_in | input | WIDTH | Asynchronous pad input levels |
| gpio_out | output | WIDTH | Output latch |
| gpio_oe | output | WIDTH | Output enable per pin |
| irq | output | 1 | Registered edge interrupt |

## Verification
The bench builds the bank with `WIDTH` = 32 and `DIR_INV` = 32'h0000_FF00. Pins 8 to 15 are therefore inverted, so the reset state and every direction write show both polarities of the output enable at once. Pad changes are timed to the clock, which brings the exact synchronizer and status latency within reach. It also lets the bench land a falling edge in the very cycle of a write-one-to-clear on the same pin.

// File: rtl/gpio_edge_bank_pkg.sv
package gpio_edge_bank_pkg;

  localparam int unsigned OFFSET_W = 8;

  localparam logic [OFFSET_W-1:0] OFF_LEVEL = 8'h00;
  localparam logic [OFFSET_W-1:0] OFF_DIR   = 8'h0C;
  localparam logic [OFFSET_W-1:0] OFF_SET   = 8'h18;
  localparam logic [OFFSET_W-1:0] OFF_CLR   = 8'h24;
  localparam logic [OFFSET_W-1:0] OFF_RISE  = 8'h30;
  localparam logic [OFFSET_W-1:0] OFF_FALL  = 8'h3C;
  localparam logic [OFFSET_W-1:0] OFF_STAT  = 8'h48;
  localparam logic [OFFSET_W-1:0] OFF_RPT   = 8'h9C;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_LEVEL,
    SEL_DIR,
    SEL_SET,
    SEL_CLR,
    SEL_RISE,
    SEL_FALL,
    SEL_STAT,
    SEL_RPT
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [OFFSET_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFF_LEVEL: s = SEL_LEVEL;
      OFF_DIR:   s = SEL_DIR;
      OFF_SET:   s = SEL_SET;
      OFF_CLR:   s = SEL_CLR;
      OFF_RISE:  s = SEL_RISE;
      OFF_FALL:  s = SEL_FALL;
      OFF_STAT:  s = SEL_STAT;
      OFF_RPT:   s = SEL_RPT;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_bank_edge.sv
module gpio_bank_edge #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] rise_en,
  input  logic [WIDTH-1:0] fall_en,
  input  logic [WIDTH-1:0] clr_bits,
  output logic [WIDTH-1:0] rise_ev,
  output logic [WIDTH-1:0] fall_ev,
  output logic [WIDTH-1:0] edge_ev,
  output logic [WIDTH-1:0] status
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] status_q;

  // New events win over a simultaneous write-one-to-clear.
  function automatic logic [WIDTH-1:0] sticky_next(
    input logic [WIDTH-1:0] cur,
    input logic [WIDTH-1:0] clr,
    input logic [WIDTH-1:0] ev
  );
    return (cur & ~clr) | ev;
  endfunction

  always_comb begin
    rise_ev = level & ~prev_q & rise_en;
    fall_ev = ~level & prev_q & fall_en;
    edge_ev = rise_ev | fall_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= level;
      status_q <= sticky_next(status_q, clr_bits, edge_ev);
    end
  end

  assign status = status_q;

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int unsigned     WIDTH   = 32,
  parameter logic [WIDTH-1:0] DIR_INV = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dir,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic             wr_rise,
  input  logic             wr_fall,
  input  logic             wr_rpt,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] rise_en_q,
  output logic [WIDTH-1:0] fall_en_q,
  output logic [WIDTH-1:0] rpt_mask_q,
  output logic [WIDTH-1:0] oe
);

  function automatic logic [WIDTH-1:0] latch_next(
    input logic [WIDTH-1:0] cur,
    input logic [WIDTH-1:0] set_bits,
    input logic [WIDTH-1:0] clr_bits
  );
    return (cur | set_bits) & ~clr_bits;
  endfunction

  function automatic logic [WIDTH-1:0] dir_to_oe(input logic [WIDTH-1:0] d);
    return d ^ DIR_INV;
  endfunction

  logic [WIDTH-1:0] set_bits;
  logic [WIDTH-1:0] clr_bits;

  assign set_bits = wr_set ? wdata : '0;
  assign clr_bits = wr_clr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q      <= '0;
      latch_q    <= '0;
      rise_en_q  <= '0;
      fall_en_q  <= '0;
      rpt_mask_q <= '0;
    end else begin
      latch_q <= latch_next(latch_q, set_bits, clr_bits);
      if (wr_dir)  dir_q      <= wdata;
      if (wr_rise) rise_en_q  <= wdata;
      if (wr_fall) fall_en_q  <= wdata;
      if (wr_rpt)  rpt_mask_q <= wdata;
    end
  end

  assign oe = dir_to_oe(dir_q);

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_bank_pkg::*;
#(
  parameter int unsigned      WIDTH   = 32,
  parameter logic [WIDTH-1:0] DIR_INV = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [OFFSET_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]    bus_wdata,
  output logic [WIDTH-1:0]    bus_rdata,
  input  logic [WIDTH-1:0]    pad_in,
  output logic [WIDTH-1:0]    gpio_out,
  output logic [WIDTH-1:0]    gpio_oe,
  output logic                irq
);

  reg_sel_e         sel;
  logic [WIDTH-1:0] pin_level;
  logic [WIDTH-1:0] dir_q, latch_q, rise_en_q, fall_en_q, rpt_mask_q;
  logic [WIDTH-1:0] rise_ev, fall_ev, edge_ev, status;
  logic [WIDTH-1:0] stat_clr;
  logic             wr_stat;
  logic             irq_q;

  assign sel      = decode_offset(bus_addr);
  assign wr_stat  = bus_we && (sel == SEL_STAT);
  assign stat_clr = wr_stat ? bus_wdata : '0;

  gpio_bank_sync #(.WIDTH(WIDTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_level)
  );

  gpio_bank_regs #(.WIDTH(WIDTH), .DIR_INV(DIR_INV)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_dir     (bus_we && (sel == SEL_DIR)),
    .wr_set     (bus_we && (sel == SEL_SET)),
    .wr_clr     (bus_we && (sel == SEL_CLR)),
    .wr_rise    (bus_we && (sel == SEL_RISE)),
    .wr_fall    (bus_we && (sel == SEL_FALL)),
    .wr_rpt     (bus_we && (sel == SEL_RPT)),
    .wdata      (bus_wdata),
    .dir_q      (dir_q),
    .latch_q    (latch_q),
    .rise_en_q  (rise_en_q),
    .fall_en_q  (fall_en_q),
    .rpt_mask_q (rpt_mask_q),
    .oe         (gpio_oe)
  );

  gpio_bank_edge #(.WIDTH(WIDTH)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (pin_level),
    .rise_en  (rise_en_q),
    .fall_en  (fall_en_q),
    .clr_bits (stat_clr),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev),
    .edge_ev  (edge_ev),
    .status   (status)
  );

  always_comb begin
    case (sel)
      SEL_LEVEL: bus_rdata = pin_level;
      SEL_DIR:   bus_rdata = dir_q;
      SEL_RISE:  bus_rdata = rise_en_q;
      SEL_FALL:  bus_rdata = fall_en_q;
      SEL_STAT:  bus_rdata = status;
      SEL_RPT:   bus_rdata = rpt_mask_q;
      default:   bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status & rpt_mask_q);
  end

  assign gpio_out = latch_q;
  assign irq      = irq_q;

endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
  import gpio_edge_bank_pkg::*;
#(
  parameter int unsigned      WIDTH   = 32,
  parameter logic [WIDTH-1:0] DIR_INV = '0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic [OFFSET_W-1:0] bus_addr,
  input logic [WIDTH-1:0]    bus_wdata,
  input logic [WIDTH-1:0]    pad_in,
  input logic [WIDTH-1:0]    pin_level,
  input logic [WIDTH-1:0]    edge_ev,
  input logic [WIDTH-1:0]    status,
  input logic [WIDTH-1:0]    rpt_mask_q,
  input logic [WIDTH-1:0]    gpio_out,
  input logic [WIDTH-1:0]    gpio_oe,
  input logic                irq
);

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_set_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_SET) |=> ((gpio_out & $past(bus_wdata)) == $past(bus_wdata)));

  assert_clr_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_CLR) |=> ((gpio_out & $past(bus_wdata)) == '0));

  assert_sync_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (pin_level == $past(pad_in, 2)));

  assert_status_needs_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(edge_ev)) == '0));

  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_STAT && edge_ev == '0) |=> ((status & $past(bus_wdata)) == '0));

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ev != '0) |=> ((status & $past(edge_ev)) == $past(edge_ev)));

  assert_dir_polarity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_DIR) |=> (gpio_oe == ($past(bus_wdata) ^ DIR_INV)));

  assert_irq_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == (|($past(status) & $past(rpt_mask_q)))));

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.WIDTH(WIDTH), .DIR_INV(DIR_INV)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .pad_in     (pad_in),
  .pin_level  (pin_level),
  .edge_ev    (edge_ev),
  .status     (status),
  .rpt_mask_q (rpt_mask_q),
  .gpio_out   (gpio_out),
  .gpio_oe    (gpio_oe),
  .irq        (irq)
);

// File: tb/test_gpio_edge_bank.sv
module test_gpio_edge_bank;

  localparam int          CLK_PERIOD = 10;
  localparam int unsigned W          = 32;
  localparam logic [W-1:0] INV       = 32'h0000_FF00;

  localparam logic [7:0] A_LEVEL = 8'h00, A_DIR = 8'h0C, A_SET = 8'h18, A_CLR = 8'h24,
                         A_RISE = 8'h30, A_FALL = 8'h3C, A_STAT = 8'h48, A_RPT = 8'h9C;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_we = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] gpio_out, gpio_oe;
  logic         irq;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  gpio_edge_bank #(.WIDTH(W), .DIR_INV(INV)) i_gpio_edge_bank (
    .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .pad_in, .gpio_out, .gpio_oe, .irq
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [W-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_pad(input logic [W-1:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    check("R11 gpio_out", gpio_out, '0);
    check("R11 gpio_oe", gpio_oe, INV);
    check("R11 irq", {31'd0, irq}, '0);
    rd(A_DIR, v);  check("R11 dir", v, '0);
    rd(A_RISE, v); check("R11 rise", v, '0);
    rd(A_FALL, v); check("R11 fall", v, '0);
    rd(A_STAT, v); check("R11 status", v, '0);
    rd(A_RPT, v);  check("R11 mask", v, '0);
  endtask

  task automatic t_map;
    logic [W-1:0] v;
    wr(A_RISE, 32'h0000_0000);
    wr(A_FALL, 32'h0000_0000);
    wr(A_DIR, 32'h1357_9BDF);
    rd(A_DIR, v); check("R1 dir readback", v, 32'h1357_9BDF);
    wr(A_SET, 32'hFFFF_0000);
    rd(A_SET, v); check("R1 set reads 0", v, '0);
    rd(A_CLR, v); check("R1 clear reads 0", v, '0);
    rd(8'h04, v); check("R1 unmapped reads 0", v, '0);
    wr(A_CLR, 32'hFFFF_FFFF);
  endtask

  task automatic t_set_clr;
    wr(A_SET, 32'hA5A5_0F0F); check("R2 set", gpio_out, 32'hA5A5_0F0F);
    wr(A_SET, 32'h0000_00F0); check("R2 set merge", gpio_out, 32'hA5A5_0FFF);
    wr(A_CLR, 32'h0F0F_0000); check("R3 clear", gpio_out, 32'hA0A0_0FFF);
    wr(A_CLR, 32'h0000_0000); check("R3 clear zero", gpio_out, 32'hA0A0_0FFF);
  endtask

  task automatic t_dir;
    wr(A_DIR, 32'hFFFF_0000); check("R9 oe inverted", gpio_oe, 32'hFFFF_FF00);
    wr(A_DIR, 32'h0000_0F0F); check("R9 oe mixed", gpio_oe, 32'h0000_F00F);
  endtask

  task automatic t_level;
    logic [W-1:0] v;
    set_pad(32'h1234_5678);
    @(negedge clk); rd(A_LEVEL, v); check("R4 level one edge", v, '0);
    @(negedge clk); rd(A_LEVEL, v); check("R4 level two edges", v, 32'h1234_5678);
    set_pad('0);
    wait_cyc(4);
    rd(A_STAT, v); check("R5 no enable no status", v, '0);
  endtask

  task automatic t_edges;
    logic [W-1:0] v;
    wr(A_RISE, 32'h0000_0003);
    set_pad(32'h0000_000F);
    wait_cyc(4);
    rd(A_STAT, v); check("R5 rising enabled only", v, 32'h0000_0003);
    wr(A_FALL, 32'h0000_000C);
    set_pad('0);
    wait_cyc(4);
    rd(A_STAT, v); check("R6 falling enabled only", v, 32'h0000_000F);
  endtask

  task automatic t_w1c;
    logic [W-1:0] v;
    wr(A_STAT, 32'h0000_0005); rd(A_STAT, v); check("R7 clear ones", v, 32'h0000_000A);
    wr(A_STAT, 32'h0000_0000); rd(A_STAT, v); check("R7 zero no effect", v, 32'h0000_000A);
    wr(A_STAT, 32'hFFFF_FFFF); rd(A_STAT, v); check("R7 clear all", v, '0);
  endtask

  task automatic t_collide;
    logic [W-1:0] v;
    wr(A_RISE, 32'h0000_0030);
    wr(A_FALL, 32'h0000_0010);
    set_pad(32'h0000_0030);
    wait_cyc(4);
    rd(A_STAT, v); check("R5 two rises", v, 32'h0000_0030);
    set_pad(32'h0000_0020);
    @(negedge clk);
    wr(A_STAT, 32'h0000_0030);
    rd(A_STAT, v); check("R8 edge beats clear", v, 32'h0000_0010);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); check("R7 clear after collide", v, '0);
  endtask

  task automatic t_irq;
    logic [W-1:0] v;
    wr(A_RISE, 32'h0000_0300);
    set_pad(32'h0000_0120);
    wait_cyc(4);
    rd(A_STAT, v); check("R5 bit8 latched", v, 32'h0000_0100);
    check("R10 masked no irq", {31'd0, irq}, '0);
    wr(A_RPT, 32'hFFFF_FFFF);
    check("R10 irq one edge late", {31'd0, irq}, '0);
    @(negedge clk); check("R10 irq raised", {31'd0, irq}, 32'd1);
    wr(A_STAT, 32'hFFFF_FFFF);
    check("R10 irq still high", {31'd0, irq}, 32'd1);
    @(negedge clk); check("R10 irq dropped", {31'd0, irq}, '0);
    set_pad(32'h0000_0320);
    wait_cyc(3); check("R10 irq before latency", {31'd0, irq}, '0);
    wait_cyc(1); check("R10 irq after edge", {31'd0, irq}, 32'd1);
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic t_restore;
    wr(A_SET, 32'hFFFF_FFFF);
    wr(A_SET, 32'h3C3C_A5A5);
    wr(A_CLR, ~32'h3C3C_A5A5);
    check("R12 restore from ones", gpio_out, 32'h3C3C_A5A5);
    wr(A_CLR, 32'hFFFF_FFFF);
    wr(A_SET, 32'h8001_7E00);
    wr(A_CLR, ~32'h8001_7E00);
    check("R12 restore from zeros", gpio_out, 32'h8001_7E00);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_map;
    t_set_clr;
    t_dir;
    t_level;
    t_edges;
    t_w1c;
    t_collide;
    t_irq;
    t_restore;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule